// File: doc/BRIEF.md
# Duplicating Fragment Generator with Retry Queue

This block produces the work items for a redundant shading array. On a start command it walks an axis-aligned rectangle of coordinates, row by row with x changing fastest and beginning at (0,0), and hands each coordinate to a downstream fragment queue over a valid/ready stream. When the redundant mode is selected, every coordinate is sent twice in consecutive beats. The two beats carry a copy tag of 0 and then 1, so a later checker can compare the two results. When the mode is off, every coordinate is sent once, and the plain path costs nothing extra.

The checker returns the coordinate of any mismatching result on a second valid/ready stream. These retry requests wait in a small FIFO. They are served ahead of the rectangle walk, so only the flagged locations are produced again, and each retried location is always sent as a tagged pair. A completion pulse marks the point where the walk is over, no retry is waiting or in flight at the output, and the checker reports through a level input that it holds no unresolved results.

Both streams follow the usual rules. A beat transfers on a cycle where valid and ready are both high. Once the output raises valid, it holds the beat unchanged until ready is seen. The retry input drops ready only when its FIFO is full. Start, mode, size, drain status and the completion pulse are plain signals.

Top module: `fraggen_dual`

## Requirements
- R1: After reset, frag_valid and done are low and rq_ready is high.
- R2: A start produces every coordinate of the width-by-height rectangle exactly once, in row-major order with x fastest, starting at (0,0).
- R3: With reliable high at the start, each rectangle coordinate is sent as two consecutive accepted beats with the same x and y, copy tag 0 first and then 1.
- R4: With reliable low at the start, each rectangle coordinate is sent as a single beat with copy tag 0.
- R5: Every accepted retry request is sent as a pair of consecutive beats (copy 0, then copy 1) at its own coordinate, whatever the mode, and retries are sent in the order they were accepted.
- R6: A waiting retry is sent before any further rectangle coordinate. It follows as soon as the pair currently being sent has finished, and it never splits a pair.
- R7: The retry FIFO holds 8 requests. If the output is stalled and empty and requests arrive back to back, exactly 9 are accepted (8 in the FIFO, 1 held at the output) before rq_ready goes low. rq_ready returns high once the output drains.
- R8: While frag_valid is high and frag_ready is low, frag_valid stays high and frag_x, frag_y and frag_copy do not change.
- R9: With frag_ready held high, the beats of one rectangle are sent on consecutive cycles with no gap.
- R10: done is a one-cycle pulse. It is raised once after the walk has ended, every retry has been sent, the output is empty and drain_idle is high. It is not raised while drain_idle is low.
- R11: A start that arrives while the walk is active is ignored. Size and mode are captured only by an accepted start.
- R12: A start with a width or height of zero sends no rectangle coordinates and is still followed by a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a rectangle walk (taken only when no walk is active) |
| dom_w | input | CW | Rectangle width, captured with start |
| dom_h | input | CW | Rectangle height, captured with start |
| reliable | input | 1 | Send each rectangle coordinate twice, captured with start |
| drain_idle | input | 1 | Checker has no unresolved results |
| rq_valid | input | 1 | Retry request present |
| rq_ready | output | 1 | Retry FIFO has room |
| rq_x | input | CW | Retry x coordinate |
| rq_y | input | CW | Retry y coordinate |
| frag_valid | output | 1 | Output beat present |
| frag_ready | input | 1 | Downstream queue accepts the beat |
| frag_x | output | CW | Output x coordinate |
| frag_y | output | CW | Output y coordinate |
| frag_copy | output | 1 | Copy tag: 0 first copy, 1 second copy |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench fills the retry FIFO while the output is stalled and counts exactly how many requests get in. A FIFO with an off-by-one full flag would drop or accept one request too many. It also injects a retry while the first copy of a pair is stuck at the output, which catches a design that lets the retry split the pair or lets the walk run ahead of the retry. Random back-pressure runs use retry coordinates outside the rectangle, so a swapped pair, a lost retry, a skipped coordinate or a single copy in redundant mode shows up as a misparsed beat sequence. Zero-sized rectangles, a start sent during a walk, and a drain input held low probe the completion pulse, which a careless design raises too early, raises twice, or never raises.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;
  // source feeding the output register on an advance cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DUP  = 2'd1,
    SRC_RQ   = 2'd2,
    SRC_DOM  = 2'd3
  } fg_src_e;
endpackage

// File: rtl/fg_reissue_fifo.sv
`timescale 1ns/1ps
module fg_reissue_fifo #(
  parameter int CW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_x,
  input  logic [CW-1:0] push_y,
  input  logic          pop,
  output logic [CW-1:0] head_x,
  output logic [CW-1:0] head_y,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2*CW-1:0] mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_FULL);
  assign head_x = mem[rp][2*CW-1:CW];
  assign head_y = mem[rp][CW-1:0];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {push_x, push_y};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: a lone push raises the occupancy by one
  p_push_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> cnt == $past(cnt) + 1'b1);
  // R7: no push is offered into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push || pop);
  // R5: the issue stage never pops an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fg_domain_walker.sv
`timescale 1ns/1ps
module fg_domain_walker #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic          step,
  output logic          active,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y
);
  logic [CW-1:0] w_r, h_r;
  logic          row_end, col_end;

  assign row_end = (cur_x == w_r - 1'b1);
  assign col_end = (cur_y == h_r - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_r    <= '0;
      h_r    <= '0;
      cur_x  <= '0;
      cur_y  <= '0;
      active <= 1'b0;
    end else if (load) begin
      w_r    <= w;
      h_r    <= h;
      cur_x  <= '0;
      cur_y  <= '0;
      active <= (w != '0) && (h != '0);
    end else if (step && active) begin
      if (row_end) begin
        cur_x <= '0;
        if (col_end) active <= 1'b0;
        else         cur_y  <= cur_y + 1'b1;
      end else begin
        cur_x <= cur_x + 1'b1;
      end
    end
  end

  // R2: inside a row x advances by one and y holds
  p_x_fastest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active && step && !load && !row_end |=>
      cur_x == $past(cur_x) + 1'b1 && cur_y == $past(cur_y));
  // R2: a row wrap returns x to zero
  p_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active && step && !load && row_end && !col_end |=>
      cur_x == '0 && cur_y == $past(cur_y) + 1'b1);
  // R2: the issue stage only steps a live walk
  p_step_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> active);
endmodule

// File: rtl/fg_issue_ctrl.sv
`timescale 1ns/1ps
module fg_issue_ctrl
  import fg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dup_dom,
  input  logic          rq_empty,
  input  logic [CW-1:0] rq_x,
  input  logic [CW-1:0] rq_y,
  output logic          rq_pop,
  input  logic          dom_active,
  input  logic [CW-1:0] dom_x,
  input  logic [CW-1:0] dom_y,
  output logic          dom_step,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y,
  output logic          out_copy,
  output logic          idle
);
  logic          adv;
  logic          pend;
  logic [CW-1:0] pend_x, pend_y;
  fg_src_e       sel;

  assign adv = !out_valid || out_ready;

  always_comb begin
    sel = SRC_NONE;
    if (adv) begin
      if (pend)            sel = SRC_DUP;
      else if (!rq_empty)  sel = SRC_RQ;
      else if (dom_active) sel = SRC_DOM;
    end
  end

  assign rq_pop   = (sel == SRC_RQ);
  assign dom_step = (sel == SRC_DOM);
  assign idle     = !out_valid && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_copy  <= 1'b0;
      pend      <= 1'b0;
      pend_x    <= '0;
      pend_y    <= '0;
    end else if (adv) begin
      case (sel)
        SRC_DUP: begin
          out_valid <= 1'b1;
          out_x     <= pend_x;
          out_y     <= pend_y;
          out_copy  <= 1'b1;
          pend      <= 1'b0;
        end
        SRC_RQ: begin
          out_valid <= 1'b1;
          out_x     <= rq_x;
          out_y     <= rq_y;
          out_copy  <= 1'b0;
          pend      <= 1'b1;
          pend_x    <= rq_x;
          pend_y    <= rq_y;
        end
        SRC_DOM: begin
          out_valid <= 1'b1;
          out_x     <= dom_x;
          out_y     <= dom_y;
          out_copy  <= 1'b0;
          pend      <= dup_dom;
          pend_x    <= dom_x;
          pend_y    <= dom_y;
        end
        default: out_valid <= 1'b0;
      endcase
    end
  end

  // R6: the walk moves only when no retry waits and no pair is open
  p_retry_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dom_step |-> rq_empty && !pend);
  // R3: a second copy is always preceded by an open first copy
  p_pair_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && pend |=> out_valid && out_copy);
endmodule

// File: rtl/fraggen_dual.sv
`timescale 1ns/1ps
module fraggen_dual #(
  parameter int CW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] dom_w,
  input  logic [CW-1:0] dom_h,
  input  logic          reliable,
  input  logic          drain_idle,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [CW-1:0] rq_x,
  input  logic [CW-1:0] rq_y,
  output logic          frag_valid,
  input  logic          frag_ready,
  output logic [CW-1:0] frag_x,
  output logic [CW-1:0] frag_y,
  output logic          frag_copy,
  output logic          done
);
  logic          dom_active, dom_step;
  logic [CW-1:0] dom_x, dom_y;
  logic          q_empty, q_full, q_pop, q_push;
  logic [CW-1:0] q_x, q_y;
  logic          issue_idle;
  logic          mode_r;
  logic          start_acc;
  logic          armed;
  logic          done_cond;
  logic [CW-1:0] lf_x, lf_y;

  assign start_acc = start && !dom_active;
  assign rq_ready  = !q_full;
  assign q_push    = rq_valid && !q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= 1'b0;
    else if (start_acc) mode_r <= reliable;
  end

  fg_domain_walker #(.CW(CW)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_acc),
    .w      (dom_w),
    .h      (dom_h),
    .step   (dom_step),
    .active (dom_active),
    .cur_x  (dom_x),
    .cur_y  (dom_y)
  );

  fg_reissue_fifo #(.CW(CW), .DEPTH(DEPTH)) u_rq (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (q_push),
    .push_x (rq_x),
    .push_y (rq_y),
    .pop    (q_pop),
    .head_x (q_x),
    .head_y (q_y),
    .empty  (q_empty),
    .full   (q_full)
  );

  fg_issue_ctrl #(.CW(CW)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .dup_dom    (mode_r),
    .rq_empty   (q_empty),
    .rq_x       (q_x),
    .rq_y       (q_y),
    .rq_pop     (q_pop),
    .dom_active (dom_active),
    .dom_x      (dom_x),
    .dom_y      (dom_y),
    .dom_step   (dom_step),
    .out_valid  (frag_valid),
    .out_ready  (frag_ready),
    .out_x      (frag_x),
    .out_y      (frag_y),
    .out_copy   (frag_copy),
    .idle       (issue_idle)
  );

  // completion: armed by new work, fired once everything has left
  assign done_cond = armed && !dom_active && q_empty && issue_idle &&
                     drain_idle && !start_acc && !q_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= done_cond;
      if (start_acc || q_push) armed <= 1'b1;
      else if (done_cond)      armed <= 1'b0;
    end
  end

  // last accepted beat, used to relate the two copies of a pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_x <= '0;
      lf_y <= '0;
    end else if (frag_valid && frag_ready) begin
      lf_x <= frag_x;
      lf_y <= frag_y;
    end
  end

  // R8: a stalled beat is held unchanged
  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=>
      frag_valid && $stable(frag_x) && $stable(frag_y) && $stable(frag_copy));
  // R3: the second copy repeats the coordinate just accepted
  p_copy_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && frag_copy |-> frag_x == lf_x && frag_y == lf_y);
  // R10: completion never overlaps live output or walk
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !frag_valid && !dom_active);
  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/fraggen_dual_test.sv
`timescale 1ns/1ps
module fraggen_dual_test;
  localparam int CW = 12;
  localparam int LOGN = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] dom_w = '0, dom_h = '0;
  logic          reliable = 1'b0;
  logic          drain_idle = 1'b1;
  logic          rq_valid = 1'b0;
  logic          rq_ready;
  logic [CW-1:0] rq_x = '0, rq_y = '0;
  logic          frag_valid;
  logic          frag_ready = 1'b0;
  logic [CW-1:0] frag_x, frag_y;
  logic          frag_copy;
  logic          done;

  always #2.5 clk = ~clk;

  fraggen_dual #(.CW(CW), .DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dom_w(dom_w), .dom_h(dom_h),
    .reliable(reliable), .drain_idle(drain_idle), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_x(rq_x), .rq_y(rq_y), .frag_valid(frag_valid),
    .frag_ready(frag_ready), .frag_x(frag_x), .frag_y(frag_y),
    .frag_copy(frag_copy), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int log_n = 0;
  int lx [LOGN];
  int ly [LOGN];
  int lc [LOGN];
  int lt [LOGN];
  int rqx [64];
  int rqy [64];
  int nrq = 0;
  int done_cnt = 0, done_wide = 0, hold_bad = 0;
  bit rnd_mode = 1'b0;
  bit p_v = 1'b0, p_r = 1'b0, p_d = 1'b0, p_c = 1'b0;
  int p_x = 0, p_y = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_v && !p_r &&
          !(frag_valid && frag_x == p_x && frag_y == p_y && frag_copy == p_c))
        hold_bad++;
      if (frag_valid && frag_ready && log_n < LOGN) begin
        lx[log_n] = int'(frag_x); ly[log_n] = int'(frag_y);
        lc[log_n] = int'(frag_copy); lt[log_n] = cyc;
        log_n++;
      end
      if (done) done_cnt++;
      if (done && p_d) done_wide++;
      p_v = frag_valid; p_r = frag_ready; p_d = done;
      p_x = int'(frag_x); p_y = int'(frag_y); p_c = frag_copy;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rnd_mode) frag_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic go(input int w, input int h, input bit rel);
    dom_w = CW'(w); dom_h = CW'(h); reliable = rel; start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic push_rq(input int x, input int y);
    rq_valid = 1'b1; rq_x = CW'(x); rq_y = CW'(y);
    forever begin
      @(negedge clk);
      if (rq_ready) begin tick(1); break; end
      tick(1);
    end
    rq_valid = 1'b0;
    rqx[nrq] = x; rqy[nrq] = y; nrq++;
  endtask

  task automatic wait_done(input int base, input string req);
    int k = 0;
    while (done_cnt <= base && k < 3000) begin @(negedge clk); k++; end
    chk(done_cnt > base, req, "done pulse seen", done_cnt - base, 1);
    tick(1);
  endtask

  // parse the recorded beats: retries have y >= h, the rest is the walk
  task automatic check_log(input int w, input int h, input bit rel, input string tag);
    int i = 0, di = 0, ri = 0, ex, ey, ax, ay;
    bit dup, bad = 1'b0;
    string why = "";
    while (i < log_n && !bad) begin
      if (lc[i] != 0) begin
        bad = 1'b1; why = rel ? "R3 first copy tag" : "R4 single copy tag";
        ax = lc[i]; ex = 0;
      end else if (ly[i] >= h) begin
        if (ri >= nrq || lx[i] != rqx[ri] || ly[i] != rqy[ri]) begin
          bad = 1'b1; why = "R5 retry coordinate/order";
          ax = lx[i] * 1000 + ly[i]; ex = (ri < nrq) ? rqx[ri] * 1000 + rqy[ri] : -1;
        end
        ri++; dup = 1'b1;
      end else begin
        ex = (w > 0) ? di % w : 0; ey = (w > 0) ? di / w : 0;
        if (lx[i] != ex || ly[i] != ey) begin
          bad = 1'b1; why = "R2 walk order";
          ax = lx[i] * 1000 + ly[i]; ex = ex * 1000 + ey;
        end
        di++; dup = rel;
      end
      if (!bad && dup) begin
        if (i + 1 >= log_n || lc[i+1] != 1 || lx[i+1] != lx[i] || ly[i+1] != ly[i]) begin
          bad = 1'b1; why = "R3 R5 second copy";
          ax = (i + 1 < log_n) ? lc[i+1] : -1; ex = 1;
        end
        i += 2;
      end else if (!bad) begin
        i += 1;
      end
    end
    if (bad) chk(1'b0, why, tag, ax, ex);
    else     chk(1'b1, "R2 R3 R5", tag, 0, 0);
    chk(di == w * h, "R2", {tag, " walk count"}, di, w * h);
    chk(ri == nrq, "R5", {tag, " retry count"}, ri, nrq);
  endtask

  initial begin
    int base, acc;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!frag_valid, "R1", "frag_valid after reset", frag_valid, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(rq_ready, "R1", "rq_ready after reset", rq_ready, 1);
    tick(1);

    // R9: full rate, redundant, ready always high
    log_n = 0; nrq = 0; frag_ready = 1'b1; base = done_cnt;
    go(4, 3, 1'b1);
    wait_done(base, "R10");
    check_log(4, 3, 1'b1, "full rate redundant");
    chk(log_n == 24 && lt[23] - lt[0] == 23, "R9", "cycle span of 24 beats",
        lt[log_n > 0 ? log_n-1 : 0] - lt[0], 23);

    // R4 + R9: plain mode
    log_n = 0; nrq = 0; base = done_cnt;
    go(5, 2, 1'b0);
    wait_done(base, "R10");
    check_log(5, 2, 1'b0, "plain mode");
    chk(log_n == 10 && lt[9] - lt[0] == 9, "R4", "single beats back to back",
        log_n, 10);

    // R6: retry arrives while a first copy is stalled at the output
    log_n = 0; nrq = 0; frag_ready = 1'b0; base = done_cnt;
    go(3, 2, 1'b1);
    tick(3);
    push_rq(7, 50);
    tick(2);
    frag_ready = 1'b1;
    wait_done(base, "R10");
    check_log(3, 2, 1'b1, "retry during stall");
    chk(lx[2] == 7 && ly[2] == 50 && lc[2] == 0, "R6", "beat 2 is the retry",
        lx[2] * 1000 + ly[2], 7050);
    chk(lx[1] == 0 && ly[1] == 0 && lc[1] == 1, "R6", "pair not split",
        lc[1], 1);

    // R7: fill the retry queue behind a stalled output
    log_n = 0; nrq = 0; frag_ready = 1'b0; base = done_cnt; acc = 0;
    for (int i = 0; i < 12; i++) begin
      rq_valid = 1'b1; rq_x = CW'(i); rq_y = CW'(100 + i);
      @(negedge clk);
      if (!rq_ready) break;
      rqx[nrq] = i; rqy[nrq] = 100 + i; nrq++; acc++;
      tick(1);
    end
    tick(3);
    chk(acc == 9, "R7", "requests taken before full", acc, 9);
    @(negedge clk);
    chk(!rq_ready, "R7", "ready low while full", rq_ready, 0);
    tick(1);
    rq_valid = 1'b0;
    frag_ready = 1'b1;
    tick(2);
    @(negedge clk);
    chk(rq_ready, "R7", "ready back after drain", rq_ready, 1);
    tick(1);
    wait_done(base, "R10");
    check_log(0, 0, 1'b0, "queue fill");

    // R12: empty rectangle still completes
    log_n = 0; nrq = 0; base = done_cnt;
    go(0, 5, 1'b1);
    wait_done(base, "R12");
    chk(log_n == 0, "R12", "beats for zero width", log_n, 0);

    // R10: drain input holds back completion
    log_n = 0; nrq = 0; drain_idle = 1'b0; base = done_cnt;
    go(2, 1, 1'b0);
    tick(30);
    chk(done_cnt == base, "R10", "done with drain low", done_cnt - base, 0);
    chk(log_n == 2, "R10", "beats sent before drain", log_n, 2);
    drain_idle = 1'b1;
    wait_done(base, "R10");
    tick(10);
    chk(done_cnt == base + 1, "R10", "exactly one pulse", done_cnt - base, 1);

    // R11: start during an active walk is ignored
    log_n = 0; nrq = 0; base = done_cnt;
    go(4, 2, 1'b1);
    tick(3);
    go(1, 1, 1'b0);
    wait_done(base, "R11");
    tick(5);
    check_log(4, 2, 1'b1, "R11 second start ignored");
    chk(log_n == 16, "R11", "beats of first rectangle", log_n, 16);

    // random back-pressure with retries outside the rectangle
    for (int it = 0; it < 8; it++) begin
      int w, h, k;
      bit rel;
      w = 1 + ($urandom % 8); h = 1 + ($urandom % 8); rel = $urandom % 2;
      k = $urandom % 5;
      log_n = 0; nrq = 0; base = done_cnt; rnd_mode = 1'b1;
      go(w, h, rel);
      for (int j = 0; j < k; j++) begin
        tick($urandom % 6);
        push_rq($urandom % 64, 200 + j);
      end
      wait_done(base, "R10");
      tick(80);
      rnd_mode = 1'b0; frag_ready = 1'b1;
      tick(5);
      check_log(w, h, rel, "random run");
    end

    chk(hold_bad == 0, "R8", "stalled beat changed", hold_bad, 0);
    chk(done_wide == 0, "R10", "done wider than one cycle", done_wide, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule